// File: doc/BRIEF.md
# Interrupt Remap Entry Allocator

This block keeps one occupancy bit for each slot of an interrupt remapping table and hands out contiguous, naturally aligned groups of slots. An allocation request names a slot count. The block rounds that count up to a power of two and then probes the table one slot per cycle. It starts at slot 0 and moves forward in steps of the rounded size. When it finds a group with no occupied slot, it marks every slot of that group occupied and returns the base slot together with the size exponent.

A release request names a base slot, a size exponent and a sub-handle. A release with sub-handle zero clears the group. In the same cycle it raises a one-cycle invalidation strobe that carries the base and the exponent, so that a downstream entry cache can drop stale copies. A release with a nonzero sub-handle belongs to a shared group and clears nothing.

The block takes one request at a time through a valid/ready handshake. It answers each request with a one-cycle done pulse and a fail flag.

Top module: `irq_remap_alloc`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` and `inv_valid` are 0, and every table slot is free.
- R2: An allocation with `req_count` equal to 0 finishes with `rsp_fail`=1 and leaves the table unchanged.
- R3: An allocation whose rounded exponent is above `MAX_EXP` fails without probing and leaves the table unchanged. A release whose `req_exp` is above `MAX_EXP` also fails and clears nothing.
- R4: The exponent of an allocation is the smallest e with 2^e >= `req_count`, so a count of 1 gives exponent 0. A successful allocation returns this value on `rsp_exp`.
- R5: Candidate bases are 0, S, 2S, … where S = 2^e. The returned base is the first candidate whose S slots are all free, so it is always a multiple of S.
- R6: When every candidate holds at least one occupied slot, the allocation fails (`rsp_fail`=1) and the table is unchanged.
- R7: A successful allocation marks all S slots of its group occupied, so later allocations never overlap it.
- R8: A release with a nonzero `req_sub` succeeds, clears no slot and raises no invalidation.
- R9: A release with `req_sub` = 0 frees the slots `req_index` … `req_index`+2^`req_exp`-1 that lie inside the table. In the cycle of its done pulse it raises `inv_valid` for one cycle, with `inv_index` = `req_index` and `inv_exp` = `req_exp`.
- R10: The request handshake is the one-cycle gap described here. An immediate response (reject or release) raises `rsp_done` in the cycle right after acceptance. A probing allocation raises `rsp_done` k cycles after acceptance, where k is the number of slots probed. `req_ready` is 0 from acceptance until the cycle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_op | input | 1 | 0 = allocate, 1 = release |
| req_count | input | CNTW | Slot count for allocation |
| req_index | input | IDXW | Base slot for release |
| req_exp | input | EXPW | Size exponent for release |
| req_sub | input | SUBW | Sub-handle for release |
| rsp_done | output | 1 | One-cycle response strobe |
| rsp_fail | output | 1 | Request failed, valid with rsp_done |
| rsp_index | output | IDXW | Base slot of the request |
| rsp_exp | output | EXPW | Size exponent of the request |
| inv_valid | output | 1 | One-cycle invalidation strobe |
| inv_index | output | IDXW | Base slot to invalidate |
| inv_exp | output | EXPW | Exponent of the range to invalidate |

## Verification
The hardest case to reach is a fragmented table. In that state large aligned groups are blocked by a single occupied slot. The probe then has to skip several strides before it succeeds, or it wraps back to slot 0 and fails.

The bench reaches this state in two ways. It fills the table one slot at a time and then releases chosen slots and groups. It also runs a long pseudo-random mix of allocations and releases against an arithmetic model of the table. In every case the bench predicts both the returned base and the exact number of probe cycles.

// File: rtl/irq_remap_alloc.sv
module irq_remap_alloc #(
  parameter int ENTRIES = 16,
  parameter int MAX_EXP = 3,
  parameter int CNTW    = 8,
  parameter int SUBW    = 4,
  parameter int IDXW    = $clog2(ENTRIES),
  parameter int EXPW    = $clog2(CNTW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_op,
  input  logic [CNTW-1:0] req_count,
  input  logic [IDXW-1:0] req_index,
  input  logic [EXPW-1:0] req_exp,
  input  logic [SUBW-1:0] req_sub,
  output logic            rsp_done,
  output logic            rsp_fail,
  output logic [IDXW-1:0] rsp_index,
  output logic [EXPW-1:0] rsp_exp,
  output logic            inv_valid,
  output logic [IDXW-1:0] inv_index,
  output logic [EXPW-1:0] inv_exp
);

  typedef enum logic {S_IDLE, S_SCAN} state_t;

  state_t             state;
  logic [ENTRIES-1:0] present;
  logic [IDXW-1:0]    base, off;
  logic [EXPW-1:0]    exp_r;
  logic               op_r;
  logic [IDXW:0]      run_len;
  logic [IDXW-1:0]    next_base;
  logic [IDXW-1:0]    probe;
  logic [EXPW-1:0]    want_exp;
  logic               accept;

  function automatic logic [EXPW-1:0] round_exp(input logic [CNTW-1:0] c);
    logic [CNTW:0] p;
    round_exp = '0;
    for (int e = CNTW; e >= 0; e--) begin
      p = (CNTW+1)'(1) << e;
      if (p >= {1'b0, c}) round_exp = EXPW'(e);
    end
  endfunction

  assign req_ready = (state == S_IDLE) && !rsp_done;
  assign accept    = req_valid && req_ready;
  assign want_exp  = round_exp(req_count);
  assign run_len   = (IDXW+1)'(1) << exp_r;
  assign probe     = base + off;
  assign next_base = base + run_len[IDXW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      present   <= '0;
      base      <= '0;
      off       <= '0;
      exp_r     <= '0;
      op_r      <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_fail  <= 1'b0;
      rsp_index <= '0;
      rsp_exp   <= '0;
      inv_valid <= 1'b0;
      inv_index <= '0;
      inv_exp   <= '0;
    end else begin
      rsp_done  <= 1'b0;
      inv_valid <= 1'b0;
      if (accept) begin
        op_r <= req_op;
        if (!req_op) begin
          rsp_exp   <= want_exp;
          rsp_index <= '0;
          if (req_count == '0 || int'(want_exp) > MAX_EXP) begin
            rsp_done <= 1'b1;
            rsp_fail <= 1'b1;
          end else begin
            state <= S_SCAN;
            base  <= '0;
            off   <= '0;
            exp_r <= want_exp;
          end
        end else begin
          rsp_done  <= 1'b1;
          rsp_index <= req_index;
          rsp_exp   <= req_exp;
          if (int'(req_exp) > MAX_EXP) begin
            rsp_fail <= 1'b1;
          end else begin
            rsp_fail <= 1'b0;
            if (req_sub == '0) begin
              for (int i = 0; i < ENTRIES; i++)
                if (i >= int'(req_index) && i < int'(req_index) + (1 << req_exp))
                  present[i] <= 1'b0;
              inv_valid <= 1'b1;
              inv_index <= req_index;
              inv_exp   <= req_exp;
            end
          end
        end
      end else if (state == S_SCAN) begin
        if (present[probe]) begin
          off <= '0;
          if (next_base == '0) begin
            state    <= S_IDLE;
            rsp_done <= 1'b1;
            rsp_fail <= 1'b1;
          end else begin
            base <= next_base;
          end
        end else if ({1'b0, off} == run_len - 1'b1) begin
          for (int i = 0; i < ENTRIES; i++)
            if (i >= int'(base) && i < int'(base) + int'(run_len))
              present[i] <= 1'b1;
          state     <= S_IDLE;
          rsp_done  <= 1'b1;
          rsp_fail  <= 1'b0;
          rsp_index <= base;
          rsp_exp   <= exp_r;
        end else begin
          off <= off + 1'b1;
        end
      end
    end
  end

  p_done_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_busy_not_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SCAN) |-> !req_ready);

  p_fail_table_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_fail) |-> $stable(present));

  p_exp_capped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail) |-> (int'(rsp_exp) <= MAX_EXP));

  p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail && !op_r) |->
      ((int'(rsp_index) % (1 << rsp_exp)) == 0));

  p_marks_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_fail && !op_r) |->
      ($countones(present) == $countones($past(present)) + (1 << rsp_exp)));

  p_inv_with_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> (rsp_done && !rsp_fail && op_r &&
                   $countones(present) <= $countones($past(present))));

endmodule

// File: tb/test_irq_remap_alloc.sv
module test_irq_remap_alloc;
  localparam int N    = 16;
  localparam int MAXE = 3;
  localparam int CNTW = 8;
  localparam int SUBW = 4;
  localparam int IDXW = 4;
  localparam int EXPW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0;
  logic [CNTW-1:0] req_count = '0;
  logic [IDXW-1:0] req_index = '0;
  logic [EXPW-1:0] req_exp = '0;
  logic [SUBW-1:0] req_sub = '0;
  logic req_ready, rsp_done, rsp_fail, inv_valid;
  logic [IDXW-1:0] rsp_index, inv_index;
  logic [EXPW-1:0] rsp_exp, inv_exp;

  always #2 clk = ~clk;

  irq_remap_alloc i_irq_remap_alloc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_count(req_count), .req_index(req_index),
    .req_exp(req_exp), .req_sub(req_sub), .rsp_done(rsp_done),
    .rsp_fail(rsp_fail), .rsp_index(rsp_index), .rsp_exp(rsp_exp),
    .inv_valid(inv_valid), .inv_index(inv_index), .inv_exp(inv_exp));

  int checks = 0, errors = 0, cycles = 0;
  bit model [N];
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic int ref_exp(input int c);
    int e = 0;
    while ((1 << e) < c) e++;
    return e;
  endfunction

  task automatic send(output int lat, output bit f, output int idx,
                      output int ex, output bit iv, output int ii, output int ie);
    while (!req_ready) @(negedge clk);
    req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 0;
    while (!rsp_done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    f = rsp_fail; idx = rsp_index; ex = rsp_exp;
    iv = inv_valid; ii = inv_index; ie = inv_exp;
  endtask

  task automatic do_alloc(input int c, output bit f, output int idx, output int ex);
    int lat, ii, ie, e, base, probes, xf;
    bit iv, found;
    req_op = 0; req_count = CNTW'(c);
    send(lat, f, idx, ex, iv, ii, ie);
    e = ref_exp(c);
    probes = 0; found = 0; base = 0;
    if (c != 0 && e <= MAXE) begin
      while (!found) begin
        bit hit = 0;
        for (int k = 0; k < (1 << e); k++) begin
          probes++;
          if (model[base + k]) begin hit = 1; break; end
        end
        if (!hit) found = 1;
        else begin
          base = (base + (1 << e)) % N;
          if (base == 0) break;
        end
      end
    end
    xf = !found;
    if (c == 0) chk(f == 1, "R2 zero count fail", f, 1);
    else if (e > MAXE) chk(f == 1, "R3 exponent over cap fail", f, 1);
    else if (!found) chk(f == 1, "R6 full table fail", f, 1);
    else begin
      chk(f == 0, "R5 alloc success", f, 0);
      chk(idx == base, "R5 first aligned free base", idx, base);
      chk(ex == e, "R4 rounded exponent", ex, e);
      for (int k = 0; k < (1 << e); k++) model[base + k] = 1;
    end
    chk(lat == probes, "R10 latency equals probes", lat, probes);
    chk(iv == 0, "R7 no invalidation on alloc", iv, 0);
    if (xf) idx = -1;
  endtask

  task automatic do_free(input int idx, input int e, input int sub);
    int lat, ri, re, ii, ie;
    bit f, iv;
    req_op = 1; req_index = IDXW'(idx); req_exp = EXPW'(e); req_sub = SUBW'(sub);
    send(lat, f, ri, re, iv, ii, ie);
    chk(lat == 0, "R10 release latency", lat, 0);
    if (e > MAXE) begin
      chk(f == 1, "R3 release exponent over cap", f, 1);
      chk(iv == 0, "R3 no invalidation", iv, 0);
    end else if (sub != 0) begin
      chk(f == 0, "R8 shared release ok", f, 0);
      chk(iv == 0, "R8 no invalidation", iv, 0);
    end else begin
      chk(f == 0, "R9 release ok", f, 0);
      chk(iv == 1, "R9 invalidation strobe", iv, 1);
      chk(ii == idx, "R9 invalidation index", ii, idx);
      chk(ie == e, "R9 invalidation exponent", ie, e);
      for (int k = 0; k < (1 << e); k++) if (idx + k < N) model[idx + k] = 0;
      @(negedge clk);
      chk(inv_valid == 0, "R9 strobe is one cycle", inv_valid, 0);
    end
    req_sub = '0;
  endtask

  initial begin
    bit f; int idx, ex;
    int held_i [N]; int held_e [N]; int nheld;
    for (int i = 0; i < N; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(rsp_done == 0, "R1 done low after reset", rsp_done, 0);
    chk(inv_valid == 0, "R1 inv low after reset", inv_valid, 0);

    // count sweep on an empty table, R4 rounding and R2/R3 rejections
    for (int c = 0; c <= 20; c++) begin
      do_alloc(c, f, idx, ex);
      if (!f) do_free(idx, ex, 0);
    end
    // empty table after all frees: a size-8 group lands at 0 (R1 table empty)
    do_alloc(8, f, idx, ex);
    chk(!f && idx == 0, "R1 table empty base", idx, 0);
    do_free(0, 3, 0);

    // fill one slot at a time, then R6 full
    for (int k = 0; k < N; k++) do_alloc(1, f, idx, ex);
    do_alloc(1, f, idx, ex);
    chk(f == 1, "R6 table full", f, 1);
    do_free(5, 0, 3);            // R8: nothing cleared
    do_alloc(1, f, idx, ex);
    chk(f == 1, "R8 shared release left slot occupied", f, 1);
    do_free(5, 0, 0);
    do_alloc(1, f, idx, ex);
    chk(!f && idx == 5, "R9 freed slot reused", idx, 5);
    do_free(4, 2, 0);
    do_alloc(3, f, idx, ex);
    chk(!f && idx == 4 && ex == 2, "R5 group in freed window", idx, 4);
    do_free(14, 3, 0);           // clears 14,15 only
    do_free(0, 4, 0);            // R3 release over cap
    do_alloc(2, f, idx, ex);
    chk(!f && idx == 14, "R9 partial range at top", idx, 14);
    do_alloc(2, f, idx, ex);
    chk(f == 1, "R7 run not reallocated", f, 1);
    for (int g = 0; g < N; g += 8) do_free(g, 3, 0);

    // pseudo-random mix against the model
    nheld = 0;
    for (int it = 0; it < 400; it++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0] && nheld > 0) begin
        int p = int'(lfsr[7:4]) % nheld;
        do_free(held_i[p], held_e[p], 0);
        held_i[p] = held_i[nheld-1]; held_e[p] = held_e[nheld-1];
        nheld--;
      end else begin
        do_alloc(int'(lfsr[11:8]) % 11, f, idx, ex);
        if (!f && idx >= 0) begin
          held_i[nheld] = idx; held_e[nheld] = ex; nheld++;
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule